// File: doc/BRIEF.md
# Setup Block Load Receiver

This block takes in a fixed-length configuration block from a host once the command that opens a setup load has been confirmed elsewhere. A start strobe arms it. It then accepts a run of data bytes followed by one check byte. It keeps a running CRC-8 over the data bytes only and holds the data in a local buffer. Any silence between bytes longer than the allowed gap cancels the load.

When the check byte arrives, the buffered data is written to a configuration store one byte at a time, over an enable/done handshake. The write happens whether or not the check byte matched. A bad check byte is reported at once with a failure code. A good one is reported with an acknowledge code, but only after the last store write has completed. A finish strobe tells the surrounding logic to resume sensing without recalibration. An abort strobe tells it that the load was dropped and normal operation resumes.

Top module: `setup_block_loader`

## Requirements
- R1: After reset the store write enable, the reply strobe, the abort strobe and the finish strobe are all low.
- R2: Data bytes are written to the store in arrival order, at addresses 0 to DATA_BYTES-1 (default 32). A write is presented with `wr_en_o` high, and its address and data are held until `wr_done_i` is seen high.
- R3: The byte that follows the DATA_BYTES-th data byte is the check byte. It is compared with a CRC-8 computed over the data bytes only: polynomial 0x07, initial value 0, bits processed MSB first, no final XOR.
- R4: On a check-byte mismatch, `reply_valid_o` pulses with `reply_data_o` = 0x00 in the clock cycle after the check byte is accepted. All data bytes are still written to the store. `finish_o` then pulses one cycle after the last write's done, and no 0xFE reply is given.
- R5: On a check-byte match, there is no reply before programming ends. `reply_valid_o` pulses with 0xFE in the same cycle as `finish_o`, one cycle after the done of the last write.
- R6: The gap counter counts 1 ms ticks and restarts at the start strobe and at every accepted byte. Up to TIMEOUT_MS (default 100) ticks are tolerated. The next tick with no byte in the same cycle pulses `abort_o` one cycle later. A byte that arrives in the same cycle as a tick counts as arriving first.
- R7: An aborted load performs no store write and gives no reply. Bytes offered while no load is armed are ignored. A later start runs a fresh, complete load.
- R8: Bytes are accepted on consecutive clock cycles with no spacing required.
- R9: While the store is being programmed, incoming bytes and ticks are ignored: they neither change the stored data nor cause an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Arms a new load (ignored while busy) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tick_1ms_i | input | 1 | One-cycle pulse every millisecond |
| wr_done_i | input | 1 | Store has completed the presented write |
| wr_en_o | output | 1 | Store write request |
| wr_addr_o | output | $clog2(DATA_BYTES) | Store write address |
| wr_data_o | output | 8 | Store write data |
| reply_valid_o | output | 1 | Reply byte strobe |
| reply_data_o | output | 8 | Reply byte (0x00 or 0xFE) |
| abort_o | output | 1 | Load cancelled by timeout |
| finish_o | output | 1 | Load complete, resume sensing without recalibration |

## Verification
Every result is one register away from the input that causes it. The failure reply appears one cycle after the check byte is sampled. Finish, and the acknowledge reply that shares its cycle, appear one cycle after the final write-done. The abort appears one cycle after the tick that passed the limit. The bench drives and observes away from the rising edge and stamps every strobe with a cycle count. It compares those stamps with the cycle in which it presented the check byte or the done, which pins each result to its exact cycle rather than just checking that it eventually appears. Timeout tests stop at exactly TIMEOUT_MS ticks, check that no abort occurred, then add one tick and check that the abort appears.

// File: rtl/setup_block_loader.sv
module setup_block_loader #(
  parameter int          DATA_BYTES = 32,
  parameter int          TIMEOUT_MS = 100,
  parameter logic [7:0]  CRC_POLY   = 8'h07,
  parameter logic [7:0]  ACK_CODE   = 8'hFE,
  parameter logic [7:0]  NAK_CODE   = 8'h00,
  localparam int         AW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          tick_1ms_i,
  input  logic          wr_done_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          reply_valid_o,
  output logic [7:0]    reply_data_o,
  output logic          abort_o,
  output logic          finish_o
);
  localparam int CW = $clog2(DATA_BYTES + 1);
  localparam int TW = $clog2(TIMEOUT_MS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_PROG} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [7:0]    crc;
  logic [TW-1:0] gap;
  logic [AW-1:0] widx;
  logic          crc_ok;
  logic [7:0]    mem [DATA_BYTES];

  function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++)
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  wire in_data  = (st == S_RECV) && rx_valid_i && (cnt < CW'(DATA_BYTES));
  wire in_check = (st == S_RECV) && rx_valid_i && (cnt == CW'(DATA_BYTES));
  wire last_wr  = (widx == AW'(DATA_BYTES - 1));

  assign wr_en_o   = (st == S_PROG);
  assign wr_addr_o = widx;
  assign wr_data_o = mem[widx];

  always_ff @(posedge clk)
    if (in_data) mem[cnt[AW-1:0]] <= rx_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cnt           <= '0;
      crc           <= '0;
      gap           <= '0;
      widx          <= '0;
      crc_ok        <= 1'b0;
      reply_valid_o <= 1'b0;
      reply_data_o  <= '0;
      abort_o       <= 1'b0;
      finish_o      <= 1'b0;
    end else begin
      reply_valid_o <= 1'b0;
      abort_o       <= 1'b0;
      finish_o      <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st  <= S_RECV;
          cnt <= '0;
          crc <= '0;
          gap <= '0;
        end
        S_RECV: begin
          if (rx_valid_i) begin
            gap <= '0;
            if (in_data) begin
              crc <= crc8_next(crc, rx_data_i);
              cnt <= cnt + 1'b1;
            end
            if (in_check) begin
              st     <= S_PROG;
              widx   <= '0;
              crc_ok <= (rx_data_i == crc);
              if (rx_data_i != crc) begin
                reply_valid_o <= 1'b1;
                reply_data_o  <= NAK_CODE;
              end
            end
          end else if (tick_1ms_i) begin
            if (gap == TW'(TIMEOUT_MS)) begin
              abort_o <= 1'b1;
              st      <= S_IDLE;
            end else begin
              gap <= gap + 1'b1;
            end
          end
        end
        S_PROG: if (wr_done_i) begin
          if (last_wr) begin
            st       <= S_IDLE;
            finish_o <= 1'b1;
            if (crc_ok) begin
              reply_valid_o <= 1'b1;
              reply_data_o  <= ACK_CODE;
            end
          end else begin
            widx <= widx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !wr_done_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_nak_at_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid_o && reply_data_o == NAK_CODE) |-> ($past(rx_valid_i) && !finish_o));

  assert_ack_after_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid_o && reply_data_o == ACK_CODE) |-> (finish_o && $past(wr_done_i)));

  assert_abort_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(tick_1ms_i && !rx_valid_i));

  assert_abort_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!wr_en_o && !finish_o && !reply_valid_o));
endmodule

// File: tb/setup_block_loader_test.sv
`timescale 1ns/1ps
module setup_block_loader_test;
  localparam int N = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       tick_1ms_i = 1'b0;
  logic       wr_done_i = 1'b0;
  logic       wr_en_o;
  logic [4:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic       reply_valid_o;
  logic [7:0] reply_data_o;
  logic       abort_o;
  logic       finish_o;

  setup_block_loader #(.DATA_BYTES(N), .TIMEOUT_MS(100)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .tick_1ms_i(tick_1ms_i), .wr_done_i(wr_done_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .reply_valid_o(reply_valid_o), .reply_data_o(reply_data_o),
    .abort_o(abort_o), .finish_o(finish_o));

  // {seed, step, corrupt, gap ticks before byte 5, done delay}
  localparam logic [39:0] VEC [0:3] = '{
    40'h00_01_00_00_00,
    40'hA5_3B_01_00_02,
    40'hFF_00_00_64_01,
    40'h10_11_01_07_03
  };

  int checks = 0, fails = 0;
  int cyc = 0, wr_n = 0, reply_n = 0, finish_n = 0, abort_n = 0;
  int reply_cyc = 0, finish_cyc = 0, last_done_cyc = 0, wait_cnt = 0;
  int wr_delay = 0;
  logic [7:0] reply_val = 8'h00;
  int         wl_addr [64];
  logic [7:0] wl_data [64];

  always @(negedge clk) begin
    #1;
    cyc++;
    if (reply_valid_o) begin reply_n++; reply_val = reply_data_o; reply_cyc = cyc; end
    if (finish_o) begin finish_n++; finish_cyc = cyc; end
    if (abort_o) abort_n++;
    if (wr_en_o && !wr_done_i) begin
      if (wait_cnt >= wr_delay) begin
        wr_done_i = 1'b1;
        wl_addr[wr_n % 64] = int'(wr_addr_o);
        wl_data[wr_n % 64] = wr_data_o;
        wr_n++;
        last_done_cyc = cyc;
        wait_cnt = 0;
      end else wait_cnt++;
    end else wr_done_i = 1'b0;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int b = 7; b >= 0; b--) begin
      fb = c[7] ^ d[b];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    tick_1ms_i = 1'b0;
    rx_valid_i = 1'b1;
    rx_data_i  = b;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); rx_valid_i = 1'b0; tick_1ms_i = 1'b1;
      @(negedge clk); tick_1ms_i = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk); rx_valid_i = 1'b0; tick_1ms_i = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run_load(input logic [7:0] seed, input logic [7:0] step,
                          input bit corrupt, input int gap, input int delay,
                          input bit inject, input string name);
    logic [7:0] crc, d;
    int bw, br, bf, ba, crc_cyc, bad;
    wr_delay = delay;
    bw = wr_n; br = reply_n; bf = finish_n; ba = abort_n;
    crc = 8'h00;
    pulse_start();
    for (int i = 0; i < N; i++) begin
      d = seed + 8'(i) * step;
      if (i == 5 && gap > 0) ticks(gap);
      put_byte(d);
      crc = crc_ref(crc, d);
    end
    put_byte(corrupt ? (crc ^ 8'h5A) : crc);
    crc_cyc = cyc;
    if (inject) begin
      for (int k = 0; k < 10; k++) begin
        put_byte(8'hAA);
        @(negedge clk); rx_valid_i = 1'b0;
      end
      ticks(110);
    end
    @(negedge clk); rx_valid_i = 1'b0;
    for (int k = 0; k < 5000 && finish_n == bf; k++) @(negedge clk);
    settle();
    check({name, " R2 write count"}, wr_n - bw, N);
    bad = 0;
    for (int i = 0; i < N; i++) begin
      d = seed + 8'(i) * step;
      if (wl_addr[(bw + i) % 64] != i || wl_data[(bw + i) % 64] != d) bad++;
    end
    check({name, " R2 R8 order and data mismatches"}, bad, 0);
    check({name, " R6 R9 no abort"}, abort_n - ba, 0);
    check({name, " finish count"}, finish_n - bf, 1);
    check({name, " R3 single reply"}, reply_n - br, 1);
    if (corrupt) begin
      check({name, " R4 reply code"}, int'(reply_val), 8'h00);
      check({name, " R4 reply cycle after check byte"}, reply_cyc, crc_cyc + 2);
      check({name, " R4 finish after last done"}, finish_cyc, last_done_cyc + 1);
    end else begin
      check({name, " R5 reply code"}, int'(reply_val), 8'hFE);
      check({name, " R5 reply with finish"}, reply_cyc, finish_cyc);
      check({name, " R5 finish after last done"}, finish_cyc, last_done_cyc + 1);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int bw, br, bf, ba;
    repeat (5) @(negedge clk);
    check("R1 wr_en after reset", int'(wr_en_o), 0);
    check("R1 reply after reset", int'(reply_valid_o), 0);
    check("R1 abort after reset", int'(abort_o), 0);
    check("R1 finish after reset", int'(finish_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 4; v++)
      run_load(VEC[v][39:32], VEC[v][31:24], VEC[v][16], int'(VEC[v][15:8]),
               int'(VEC[v][7:0]), 1'b0, $sformatf("vec%0d", v));

    // R7: bytes with no armed load
    bw = wr_n; br = reply_n; bf = finish_n;
    for (int i = 0; i < 40; i++) put_byte(8'(i));
    settle();
    check("R7 unarmed bytes write", wr_n - bw, 0);
    check("R7 unarmed bytes reply", reply_n - br + finish_n - bf, 0);

    // R6: armed but silent
    ba = abort_n; bw = wr_n;
    pulse_start();
    ticks(100);
    settle();
    check("R6 limit ticks no abort", abort_n - ba, 0);
    ticks(1);
    settle();
    check("R6 tick past limit aborts", abort_n - ba, 1);
    check("R7 abort writes nothing", wr_n - bw, 0);

    // R6: tick coinciding with a byte
    ba = abort_n; bw = wr_n; br = reply_n;
    pulse_start();
    for (int i = 0; i < 3; i++) put_byte(8'h30 + 8'(i));
    ticks(100);
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 8'h77; tick_1ms_i = 1'b1;
    settle();
    check("R6 byte beats coincident tick", abort_n - ba, 0);
    ticks(100);
    settle();
    check("R6 gap restarted by byte", abort_n - ba, 0);
    ticks(1);
    settle();
    check("R6 abort after partial block", abort_n - ba, 1);
    check("R7 partial block discarded", wr_n - bw, 0);
    check("R7 partial block no reply", reply_n - br, 0);

    // R7: fresh load after abort; R9: noise during programming
    run_load(8'h3C, 8'h05, 1'b0, 0, 0, 1'b0, "after_abort R7");
    run_load(8'h81, 8'h13, 1'b0, 0, 10, 1'b1, "prog_noise R9");

    summary();
  end
endmodule